// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a virtual address into a physical address by reading a four-level radix page table that lives in ordinary memory. A client hands it one translation at a time over a valid/ready request channel, carrying the virtual address and a write flag. The walker cuts the address into four 9-bit table indices and a 12-bit page offset. It then fetches one 64-bit entry per level through a valid/ready memory port, starting at the table named by the root-pointer input. It hands back either the physical address or a fault with a cause code and the level at which the walk stopped.

Writability is gathered along the path. A write is refused as soon as any level on the path lacks write permission. A read that completes reports whether a write through the same path would have been allowed. A clear present bit ends the walk at once. A virtual address whose upper bits do not sign-extend bit 47 is refused before any memory traffic.

Back-pressure rules: the translation request is taken only while the walker is idle. A response stays valid and unchanged until the client raises ready, and no new request is taken before that. On the memory side, a request stays valid with the same address until it is accepted. Only one read is outstanding at a time, and the walker raises response-ready only while that read is in flight. The root pointer is sampled when a translation is accepted.

Top module: `pgw_top`

## Requirements
- R1: Each memory read address is the current table base with its low 12 bits zero, plus the 9-bit index for that level times 8. Level 4 uses virtual bits 47:39, level 3 uses 38:30, level 2 uses 29:21 and level 1 uses 20:12.
- R2: A walk reads level 4 first, then levels 3, 2 and 1, which is four reads in all. The first base is root-pointer bits 51:12, and bits 11:0 of the root pointer are ignored. Each later base is bits 51:12 of the entry just read.
- R3: A successful walk returns cause 0, level 0, and the level-1 entry's frame (bits 51:12) followed by virtual bits 11:0 as the physical address.
- R4: An entry with bit 0 (present) clear stops the walk with no further reads. The walker returns cause 1, a physical address of 0, and the level of that table (4, 3, 2 or 1).
- R5: A write access that meets a present entry with bit 1 (writable) clear stops at that level with no further reads. The walker returns cause 2, that level, and a physical address of 0. A read access is not stopped by a clear writable bit.
- R6: On success the write-allowed output is 1 only if bit 1 was set in all four entries on the path.
- R7: A virtual address whose bits 63:48 are not all equal to bit 47 returns cause 3 and level 0, and no memory read is issued.
- R8: Virtual bits 63:48 of a canonical address take no part in indexing. Entry bits 63:52 and 11:0 take no part in forming the next base.
- R9: A memory request holds valid and its address until accepted. No new request is issued while a read is outstanding, and no request is issued while the walker is idle.
- R10: Translation-request ready is high exactly while the walker is idle. A response holds valid and all its fields until accepted.
- R11: After reset the walker is idle, with request ready high and no memory request, memory response ready or translation response asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_ptr | input | 52 | Physical address of the level-4 table; bits 11:0 ignored |
| tr_req_valid | input | 1 | Translation request valid |
| tr_req_ready | output | 1 | Walker idle and able to take a request |
| tr_req_vaddr | input | 64 | Virtual address to translate |
| tr_req_write | input | 1 | 1 for a write access |
| tr_rsp_valid | output | 1 | Translation result valid |
| tr_rsp_ready | input | 1 | Client takes the result |
| tr_rsp_paddr | output | 52 | Physical address (0 on fault) |
| tr_rsp_wr_ok | output | 1 | All levels on the path writable |
| tr_rsp_cause | output | 2 | 0 ok, 1 not present, 2 write protected, 3 non-canonical |
| tr_rsp_level | output | 3 | Level where the walk stopped (0 for ok or non-canonical) |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 52 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_ready | output | 1 | Walker waiting for entry data |
| mem_rsp_data | input | 64 | Entry value |

## Verification
The bench builds the walker with its default parameters: four levels, 9-bit indices, a 12-bit offset and 52 physical bits. These values put the real table geometry within reach. Index 511 reaches the last slot of a table, a sign-extended upper-half address lands on slot 257 of the root table, and entries carrying junk in bits 63:52 show that those bits are masked. The memory and the client stall both handshakes on a rotating pattern, so holds under back-pressure are exercised at every level of a walk.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    PGW_OK       = 2'd0,
    PGW_ABSENT   = 2'd1,
    PGW_WRPROT   = 2'd2,
    PGW_NONCANON = 2'd3
  } pgw_cause_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_RESP
  } pgw_state_e;

  localparam int ENTRY_W      = 64;
  localparam int PRESENT_BIT  = 0;
  localparam int WRITABLE_BIT = 1;
endpackage

// File: rtl/pgw_canon_chk.sv
// Flags whether the bits above the translated span sign-extend its top bit.
module pgw_canon_chk #(
  parameter int VA_W = 48
) (
  input  logic [63:0] vaddr,
  output logic        canonical
);
  localparam int EXT_W = 64 - VA_W + 1;

  logic [EXT_W-1:0] ext_bits;
  logic unused_low;

  assign ext_bits   = vaddr[63:VA_W-1];
  assign canonical  = (&ext_bits) | ~(|ext_bits);
  assign unused_low = ^vaddr[VA_W-2:0];
endmodule

// File: rtl/pgw_va_split.sv
// Cuts the latched virtual address into one index per level plus the offset.
module pgw_va_split #(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  localparam int VA_W  = LEVELS * IDX_W + OFF_W
) (
  input  logic [VA_W-1:0]         va,
  output logic [LEVELS*IDX_W-1:0] idx_flat,
  output logic [OFF_W-1:0]        offset
);
  assign offset = va[OFF_W-1:0];

  // Slot k of idx_flat serves table level k+1.
  for (genvar k = 0; k < LEVELS; k++) begin : g_idx
    assign idx_flat[k*IDX_W +: IDX_W] = va[OFF_W + k*IDX_W +: IDX_W];
  end
endmodule

// File: rtl/pgw_entry_dec.sv
// Pulls the flag bits and the next base out of one table entry.
module pgw_entry_dec import pgw_pkg::*; #(
  parameter int PA_W  = 52,
  parameter int OFF_W = 12,
  localparam int FB_W = PA_W - OFF_W
) (
  input  logic [ENTRY_W-1:0] entry,
  output logic               present,
  output logic               writable,
  output logic [FB_W-1:0]    next_base
);
  logic unused_bits;

  assign present     = entry[PRESENT_BIT];
  assign writable    = entry[WRITABLE_BIT];
  assign next_base   = entry[PA_W-1:OFF_W];
  assign unused_bits = ^{entry[ENTRY_W-1:PA_W], entry[OFF_W-1:WRITABLE_BIT+1]};
endmodule

// File: rtl/pgw_walk_ctl.sv
// Sequencer: takes a request, issues one read per level, decides the outcome.
module pgw_walk_ctl import pgw_pkg::*; #(
  parameter int PA_W   = 52,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  localparam int FB_W  = PA_W - OFF_W,
  localparam int VA_W  = LEVELS * IDX_W + OFF_W,
  localparam int LVL_W = $clog2(LEVELS),
  localparam int REP_W = $clog2(LEVELS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [FB_W-1:0]         root_base,
  input  logic                    tr_req_valid,
  output logic                    tr_req_ready,
  input  logic [VA_W-1:0]         va_in,
  input  logic                    va_canonical,
  input  logic                    wr_in,
  output logic [VA_W-1:0]         va_q,
  input  logic [LEVELS*IDX_W-1:0] idx_flat,
  input  logic [OFF_W-1:0]        offset,
  output logic                    tr_rsp_valid,
  input  logic                    tr_rsp_ready,
  output logic [PA_W-1:0]         rsp_paddr,
  output logic                    rsp_wr_ok,
  output logic [1:0]              rsp_cause,
  output logic [REP_W-1:0]        rsp_level,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [PA_W-1:0]         mem_req_addr,
  input  logic                    mem_rsp_valid,
  output logic                    mem_rsp_ready,
  input  logic                    ent_present,
  input  logic                    ent_writable,
  input  logic [FB_W-1:0]         ent_base
);
  localparam int ESZ_W = OFF_W - IDX_W;   // log2 of the entry size in bytes

  pgw_state_e       state_q;
  logic [LVL_W-1:0] lvl_q;
  logic [FB_W-1:0]  base_q;
  logic             wr_q;
  logic             wok_q;
  pgw_cause_e       cause_q;
  logic [REP_W-1:0] stop_lvl_q;
  logic [IDX_W-1:0] idx_cur;
  logic [REP_W-1:0] lvl_num;

  assign idx_cur = idx_flat[int'(lvl_q)*IDX_W +: IDX_W];
  assign lvl_num = REP_W'(lvl_q) + REP_W'(1);

  assign tr_req_ready  = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_rsp_ready = (state_q == ST_WAIT);
  assign tr_rsp_valid  = (state_q == ST_RESP);
  // Table bases are page aligned, so base + index*8 is a plain concatenation.
  assign mem_req_addr  = {base_q, idx_cur, {ESZ_W{1'b0}}};

  assign rsp_cause = cause_q;
  assign rsp_level = stop_lvl_q;
  assign rsp_wr_ok = (cause_q == PGW_OK) && wok_q;
  assign rsp_paddr = (cause_q == PGW_OK) ? {base_q, offset} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      lvl_q      <= '0;
      base_q     <= '0;
      va_q       <= '0;
      wr_q       <= 1'b0;
      wok_q      <= 1'b0;
      cause_q    <= PGW_OK;
      stop_lvl_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (tr_req_valid) begin
            va_q       <= va_in;
            wr_q       <= wr_in;
            wok_q      <= 1'b1;
            lvl_q      <= LVL_W'(LEVELS - 1);
            base_q     <= root_base;
            stop_lvl_q <= '0;
            if (!va_canonical) begin
              cause_q <= PGW_NONCANON;
              state_q <= ST_RESP;
            end else begin
              cause_q <= PGW_OK;
              state_q <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (!ent_present) begin
              cause_q    <= PGW_ABSENT;
              stop_lvl_q <= lvl_num;
              state_q    <= ST_RESP;
            end else if (wr_q && !ent_writable) begin
              cause_q    <= PGW_WRPROT;
              stop_lvl_q <= lvl_num;
              state_q    <= ST_RESP;
            end else begin
              wok_q  <= wok_q & ent_writable;
              base_q <= ent_base;
              if (lvl_q == '0) begin
                state_q <= ST_RESP;
              end else begin
                lvl_q   <= lvl_q - LVL_W'(1);
                state_q <= ST_REQ;
              end
            end
          end
        end
        ST_RESP: begin
          if (tr_rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgw_top.sv
module pgw_top import pgw_pkg::*; #(
  parameter int PA_W   = 52,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   root_ptr,
  input  logic              tr_req_valid,
  output logic              tr_req_ready,
  input  logic [63:0]       tr_req_vaddr,
  input  logic              tr_req_write,
  output logic              tr_rsp_valid,
  input  logic              tr_rsp_ready,
  output logic [PA_W-1:0]   tr_rsp_paddr,
  output logic              tr_rsp_wr_ok,
  output logic [1:0]        tr_rsp_cause,
  output logic [2:0]        tr_rsp_level,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [63:0]       mem_rsp_data
);
  localparam int VA_W = LEVELS * IDX_W + OFF_W;
  localparam int FB_W = PA_W - OFF_W;

  logic                    canonical;
  logic [VA_W-1:0]         va_q;
  logic [LEVELS*IDX_W-1:0] idx_flat;
  logic [OFF_W-1:0]        offset;
  logic                    ent_present;
  logic                    ent_writable;
  logic [FB_W-1:0]         ent_base;
  logic                    unused_root;

  assign unused_root = ^root_ptr[OFF_W-1:0];

  pgw_canon_chk #(.VA_W(VA_W)) canon_i (
    .vaddr     (tr_req_vaddr),
    .canonical (canonical)
  );

  pgw_va_split #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W)) split_i (
    .va       (va_q),
    .idx_flat (idx_flat),
    .offset   (offset)
  );

  pgw_entry_dec #(.PA_W(PA_W), .OFF_W(OFF_W)) dec_i (
    .entry     (mem_rsp_data),
    .present   (ent_present),
    .writable  (ent_writable),
    .next_base (ent_base)
  );

  pgw_walk_ctl #(.PA_W(PA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W)) ctl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .root_base     (root_ptr[PA_W-1:OFF_W]),
    .tr_req_valid  (tr_req_valid),
    .tr_req_ready  (tr_req_ready),
    .va_in         (tr_req_vaddr[VA_W-1:0]),
    .va_canonical  (canonical),
    .wr_in         (tr_req_write),
    .va_q          (va_q),
    .idx_flat      (idx_flat),
    .offset        (offset),
    .tr_rsp_valid  (tr_rsp_valid),
    .tr_rsp_ready  (tr_rsp_ready),
    .rsp_paddr     (tr_rsp_paddr),
    .rsp_wr_ok     (tr_rsp_wr_ok),
    .rsp_cause     (tr_rsp_cause),
    .rsp_level     (tr_rsp_level),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .ent_present   (ent_present),
    .ent_writable  (ent_writable),
    .ent_base      (ent_base)
  );
endmodule

// File: rtl/pgw_check.sv
module pgw_check #(
  parameter int PA_W   = 52,
  parameter int LEVELS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tr_req_valid,
  input logic            tr_req_ready,
  input logic [63:0]     tr_req_vaddr,
  input logic            tr_rsp_valid,
  input logic            tr_rsp_ready,
  input logic [PA_W-1:0] tr_rsp_paddr,
  input logic [1:0]      tr_rsp_cause,
  input logic [2:0]      tr_rsp_level,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            mem_rsp_ready
);
  logic outst_q;     // a memory read is in flight
  logic nc_q;        // a non-canonical translation is being answered
  logic in_nc;

  assign in_nc = (tr_req_vaddr[63:47] != '0) && (tr_req_vaddr[63:47] != '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst_q <= 1'b0;
      nc_q    <= 1'b0;
    end else begin
      if (mem_req_valid && mem_req_ready)      outst_q <= 1'b1;
      else if (mem_rsp_valid && mem_rsp_ready) outst_q <= 1'b0;
      if (tr_req_valid && tr_req_ready)        nc_q <= in_nc;
      else if (tr_rsp_valid && tr_rsp_ready)   nc_q <= 1'b0;
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_single_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |-> !outst_q);

  assert_rsp_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> outst_q);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tr_rsp_valid && !tr_rsp_ready |=> tr_rsp_valid && $stable(tr_rsp_paddr)
      && $stable(tr_rsp_cause) && $stable(tr_rsp_level));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tr_rsp_valid |-> !tr_req_ready);

  assert_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nc_q |-> !mem_req_valid);

  assert_nc_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tr_rsp_valid && tr_rsp_cause == 2'd3 |-> tr_rsp_level == 3'd0);

  assert_ok_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tr_rsp_valid && tr_rsp_cause == 2'd0 |-> tr_rsp_level == 3'd0);

  assert_fault_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tr_rsp_valid && (tr_rsp_cause == 2'd1 || tr_rsp_cause == 2'd2)
      |-> tr_rsp_level != 3'd0 && 32'(tr_rsp_level) <= LEVELS && tr_rsp_paddr == '0);
endmodule

bind pgw_top pgw_check #(.PA_W(PA_W), .LEVELS(LEVELS)) chk_i (.*);

// File: tb/pgw_top_tb_top.sv
`timescale 1ns/1ps
module pgw_top_tb_top;
  localparam int NCASE = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [51:0] root_ptr;
  logic        tr_req_valid, tr_req_ready, tr_req_write;
  logic [63:0] tr_req_vaddr;
  logic        tr_rsp_valid, tr_rsp_ready, tr_rsp_wr_ok;
  logic [51:0] tr_rsp_paddr;
  logic [1:0]  tr_rsp_cause;
  logic [2:0]  tr_rsp_level;
  logic        mem_req_valid, mem_req_ready;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid, mem_rsp_ready;
  logic [63:0] mem_rsp_data;

  always #4 clk = ~clk;

  pgw_top dut_i (.*);

  int n_cmp = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [63:0] mem_img [logic [63:0]];
  logic [63:0] c_va [NCASE];
  bit          c_wr [NCASE];
  string       c_tag [NCASE];

  int          exp_cause, exp_lvl;
  logic [51:0] exp_pa;
  bit          exp_wok;
  logic [51:0] exp_reads [$];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(logic [63:0] a);
    return mem_img.exists(a) ? mem_img[a] : 64'd0;
  endfunction

  // Behavioural walk over the sparse memory image.
  task automatic model(input logic [63:0] va, input bit wr);
    logic [63:0] base, e, a;
    int idx;
    exp_reads.delete();
    exp_cause = 0; exp_lvl = 0; exp_pa = '0; exp_wok = 1;
    if (va[63:47] != 17'h0 && va[63:47] != 17'h1ffff) begin
      exp_cause = 3; exp_wok = 0;
      return;
    end
    base = {12'd0, root_ptr} & ~64'hfff;
    for (int lv = 4; lv >= 1; lv--) begin
      idx = int'((va >> (12 + 9 * (lv - 1))) & 64'h1ff);
      a = base + 64'(idx) * 8;
      exp_reads.push_back(a[51:0]);
      e = rd(a);
      if (!e[0]) begin exp_cause = 1; exp_lvl = lv; exp_wok = 0; return; end
      if (!e[1]) begin
        if (wr) begin exp_cause = 2; exp_lvl = lv; exp_wok = 0; return; end
        exp_wok = 0;
      end
      base = e & 64'h000f_ffff_ffff_f000;
    end
    exp_pa = base[51:0] | {40'd0, va[11:0]};
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit          req_fire = 0, rsp_fire = 0, trq_fire = 0, trs_fire = 0;
    bit          busy = 0, have_pend = 0;
    logic [51:0] req_cap = '0;
    logic [63:0] pend_data = '0;
    int          pend_dly = 0, cyc = 0, case_i = 0;
    string       cur_tag = "";

    // Table tree: root at 0x1000, then 0x4000, 0x6000, leaf table 0x8000.
    mem_img[64'h1008] = 64'h4003;
    mem_img[64'h4000] = 64'h6003;
    mem_img[64'h6ff8] = 64'h8003;
    mem_img[64'h83f8] = 64'hc001;                 // leaf read-only -> 0xC000
    mem_img[64'h8000] = 64'h2023;                 // leaf writable, accessed -> 0x2000
    mem_img[64'h1018] = 64'ha001;                 // root slot 3 read-only
    mem_img[64'ha000] = 64'h6003;
    mem_img[64'h1808] = 64'h4003;                 // root slot 257
    mem_img[64'h1020] = 64'hfff0_0000_0000_4003;  // junk above bit 51

    c_va[0]  = 64'h0000_0080_3fe7_f5ce; c_wr[0]  = 0; c_tag[0]  = "R3";
    c_va[1]  = 64'h0000_0080_3fe7_f5ce; c_wr[1]  = 1; c_tag[1]  = "R5";
    c_va[2]  = 64'h0000_0080_3fe0_0123; c_wr[2]  = 1; c_tag[2]  = "R6";
    c_va[3]  = 64'h0000_0100_0000_0000; c_wr[3]  = 0; c_tag[3]  = "R4";
    c_va[4]  = 64'h0000_0080_00a0_0000; c_wr[4]  = 0; c_tag[4]  = "R4";
    c_va[5]  = 64'h0000_0180_3fe0_0007; c_wr[5]  = 0; c_tag[5]  = "R6";
    c_va[6]  = 64'h0000_0180_3fe0_0007; c_wr[6]  = 1; c_tag[6]  = "R5";
    c_va[7]  = 64'h0000_8000_0000_0000; c_wr[7]  = 0; c_tag[7]  = "R7";
    c_va[8]  = 64'h1234_0000_0000_0000; c_wr[8]  = 1; c_tag[8]  = "R7";
    c_va[9]  = 64'hffff_8000_0000_0000; c_wr[9]  = 0; c_tag[9]  = "R8";
    c_va[10] = 64'hffff_8080_3fe7_f5ce; c_wr[10] = 0; c_tag[10] = "R8";
    c_va[11] = 64'h0000_0200_3fe7_f5ce; c_wr[11] = 0; c_tag[11] = "R8";

    rst_n = 0;
    root_ptr = 52'h1a5c;   // low 12 bits must be ignored (R2)
    tr_req_valid = 0; tr_req_vaddr = '0; tr_req_write = 0; tr_rsp_ready = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk("R11", 64'(tr_req_ready), 64'd1);
    chk("R11", 64'(mem_req_valid), 64'd0);
    chk("R11", 64'(mem_rsp_ready), 64'd0);
    chk("R11", 64'(tr_rsp_valid), 64'd0);

    while (!(case_i == NCASE && !busy && !trq_fire)) begin
      @(negedge clk);
      // Effects of the handshakes that completed at the last rising edge.
      if (req_fire) begin
        pend_data = rd({12'd0, req_cap});
        pend_dly  = cyc % 3;
        have_pend = 1;
        if (exp_reads.size() > 0) void'(exp_reads.pop_front());
      end
      if (rsp_fire) mem_rsp_valid = 0;
      if (trq_fire) begin
        model(c_va[case_i], c_wr[case_i]);
        cur_tag = c_tag[case_i];
        busy = 1;
        tr_req_valid = 0;
        case_i++;
      end
      if (trs_fire) busy = 0;

      cyc++;
      mem_req_ready = (cyc % 4) != 1;
      tr_rsp_ready  = (cyc % 5) != 2;
      if (have_pend && !mem_rsp_valid) begin
        if (pend_dly == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data  = pend_data;
          have_pend     = 0;
        end else begin
          pend_dly--;
        end
      end
      if (!tr_req_valid && case_i < NCASE && (cyc % 2) == 0) begin
        tr_req_valid = 1;
        tr_req_vaddr = c_va[case_i];
        tr_req_write = c_wr[case_i];
      end
      #1;

      // Per-clock comparison against the model.
      chk("R10", 64'(tr_req_ready), 64'(!busy));
      if (mem_req_valid) begin
        if (!busy || exp_reads.size() == 0)
          chk("R9", 64'(mem_req_valid), 64'd0);
        else
          chk("R1 R2", 64'(mem_req_addr), 64'(exp_reads[0]));
      end
      if (tr_rsp_valid && tr_rsp_ready) begin
        chk(cur_tag, 64'(tr_rsp_cause), 64'(exp_cause));
        chk(cur_tag, 64'(tr_rsp_level), 64'(exp_lvl));
        chk(cur_tag, 64'(tr_rsp_paddr), 64'(exp_pa));
        chk("R6", 64'(tr_rsp_wr_ok), 64'(exp_wok));
        chk("R9", 64'(exp_reads.size()), 64'd0);
      end

      req_fire = mem_req_valid && mem_req_ready;
      req_cap  = mem_req_addr;
      rsp_fire = mem_rsp_valid && mem_rsp_ready;
      trq_fire = tr_req_valid && tr_req_ready;
      trs_fire = tr_rsp_valid && tr_rsp_ready;
    end

    // The worked example from the requirements must land on 0xC5CE.
    model(c_va[0], 1'b0);
    chk("R3", 64'(exp_pa), 64'hc5ce);

    finished = 1;
    summary();
    $finish;
  end
endmodule